// File: doc/BRIEF.md
# Fractional clock scaler with kick handshake

This block turns a fast parent clock into a clock-enable stream whose average rate is the parent rate times `mult / 32`, where `mult` runs from 1 to 32. Parent cycles are grouped into 32-cycle frames that start from reset. In each frame, exactly `mult` cycles carry an enable. A phase accumulator spaces these kept cycles as evenly as it can, so that the idle stretches between them stay short.

Software reaches two 32-bit registers over a plain register bus with read strobe, write strobe, address and data. The ratio register holds a 5-bit code equal to `32 - mult`. Writing that code only changes a pending copy. The rate changes when software sets a kick bit in a separate control register. Hardware then moves the pending code into the live setting on the last cycle of the current frame and clears the kick bit in that same cycle. Software polls the kick bit to learn that the change has happened. While a kick is pending, writes to the ratio register are refused, so the value that gets applied is always the one the kick was issued for.

Top module: `frac_clk_scaler`

## Requirements
- R1: After reset, both registers read 0 and `clk_en` is high in all 32 cycles of every frame (full rate).
- R2: The ratio register sits at byte address 0x0E0. All 32 bits read back as written. Bits 12:8 hold the code `32 - mult`, and code 0 means `mult` = 32.
- R3: The control register sits at byte address 0x004. Bits 30:0 read back as written. Writing 1 to bit 31 sets the pending kick. Writing 0 to bit 31 does not clear a kick that is already pending.
- R4: A ratio register write with no kick issued after it leaves the output rate unchanged.
- R5: Frame phase 0 is the first cycle after reset is released, and the phase then counts 0 to 31 without stopping. A kick that is pending during phase 31 clears at the end of that cycle, and the new code governs from the following phase 0. A kick written during phase 31 is applied one full frame later.
- R6: Every frame with a settled ratio holds exactly `mult` enable cycles.
- R7: Within a frame, the longest run of consecutive cycles without an enable is `ceil(32/mult) - 1`.
- R8: While a kick is pending, writes to the ratio register are ignored as a whole word. This holds in the very cycle the kick is applied. The ratio that gets applied is the one stored before the kick.
- R9: A read of any other address returns 0, and a write to it changes nothing. `reg_rdata` is 0 whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the registers |
| clk_en | output | 1 | Scaled clock enable, one parent cycle wide |

## Verification
Two events can fall in the same cycle. The first is the frame-end apply of a pending kick. The second is a software access that either issues a kick or rewrites the ratio register. The bench aligns to the frame phase it counts itself from reset release. It then places a kick write in phase 31, which must not be applied until a full frame later (31 busy polls, then a clear seen in phase 0). It also places a ratio write in the apply cycle of a pending kick, which must be refused: the register reads back the older value, and the frame enable count matches that older ratio.

// File: rtl/fcs_pkg.sv
// Shared declarations for the fractional clock scaler.
// Assumes a single register bus decode of two registers.
package fcs_pkg;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RATIO = 2'd1,
        SEL_CTRL  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/fcs_regs.sv
// Register file of the scaler: the ratio register (pending copy) and the
// control register with its self-clearing kick bit.
// Assumes single-cycle write strobes. Read data is combinational.
// A pending kick blocks every write to the ratio register.
module fcs_regs
    import fcs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int FRAC_W    = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter logic [ADDR_W-1:0] RATIO_ADDR = 12'h0E0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              apply,
    output logic [FRAC_W-1:0] pend_field,
    output logic              kick_pend
);

    localparam logic [DATA_W-1:0] KICK_MASK = DATA_W'(1) << KICK_BIT;

    reg_sel_e          sel;
    logic [DATA_W-1:0] ratio_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              kick_next;
    logic [DATA_W-1:0] ctrl_rest_next;

    // Address decode for the two registers
    always_comb begin
        if (addr == RATIO_ADDR)     sel = SEL_RATIO;
        else if (addr == CTRL_ADDR) sel = SEL_CTRL;
        else                        sel = SEL_NONE;
    end

    assign kick_pend  = ctrl_q[KICK_BIT];
    assign pend_field = ratio_q[FIELD_LSB +: FRAC_W];

    // Ratio register: write accepted only while no kick is pending
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= '0;
        else if (wr_en && sel == SEL_RATIO && !kick_pend)
            ratio_q <= wdata;
    end

    // Next kick bit: hardware clear wins, software may only set it
    always_comb begin
        if (apply)
            kick_next = 1'b0;
        else
            kick_next = kick_pend | (wr_en && sel == SEL_CTRL && wdata[KICK_BIT]);
    end

    // Next value of the control bits other than the kick
    always_comb begin
        if (wr_en && sel == SEL_CTRL)
            ctrl_rest_next = wdata & ~KICK_MASK;
        else
            ctrl_rest_next = ctrl_q & ~KICK_MASK;
    end

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_rest_next | (kick_next ? KICK_MASK : '0);
    end

    // Combinational read mux, zero when not reading or unmapped
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_RATIO: rdata = ratio_q;
                SEL_CTRL:  rdata = ctrl_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fcs_phase.sv
// Free-running frame phase counter of 2**FRAC_W cycles, reset to phase 0.
// Flags the last cycle of each frame.
module fcs_phase #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [FRAC_W-1:0] phase,
    output logic              last_phase
);

    // Advance the phase every parent cycle
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    assign last_phase = &phase;

endmodule

// File: rtl/fcs_update.sv
// Holds the live ratio code. It loads the pending code on the last frame
// cycle while a kick is pending and reports that apply to the register
// file, which clears the kick. Turns the code into the multiplier.
module fcs_update #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_pend,
    input  logic              last_phase,
    input  logic [FRAC_W-1:0] pend_field,
    output logic              apply,
    output logic [FRAC_W-1:0] active_field,
    output logic [FRAC_W:0]   mult
);

    localparam logic [FRAC_W:0] FULL = (FRAC_W+1)'(1) << FRAC_W;

    assign apply = kick_pend & last_phase;

    // Live code register, changes only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)     active_field <= '0;
        else if (apply) active_field <= pend_field;
    end

    assign mult = FULL - {1'b0, active_field};

endmodule

// File: rtl/fcs_accum.sv
// Pulse-keeping enable generator. Each cycle it adds mult to a FRAC_W-bit
// phase accumulator and asserts the enable on every carry out. Assumes mult
// changes only where the accumulator is zero, which is the frame boundary.
module fcs_accum #(
    parameter int FRAC_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FRAC_W:0] mult,
    output logic            en
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc_q} + mult;
    assign en  = sum[FRAC_W];

    // Keep the residue modulo the frame length
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/frac_clk_scaler.sv
// Top of the fractional clock scaler. It joins the register file, the frame
// phase counter, the frame-aligned update stage and the accumulator.
// Assumes one parent clock domain and a synchronous active-low reset.
module frac_clk_scaler #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int FRAC_W    = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter logic [ADDR_W-1:0] RATIO_ADDR = 12'h0E0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);

    logic [FRAC_W-1:0] phase;
    logic              last_phase;
    logic              apply;
    logic              kick_pend;
    logic [FRAC_W-1:0] pend_field;
    logic [FRAC_W-1:0] active_field;
    logic [FRAC_W:0]   mult;

    fcs_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
        .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT),
        .RATIO_ADDR(RATIO_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .apply(apply), .pend_field(pend_field), .kick_pend(kick_pend)
    );

    fcs_phase #(.FRAC_W(FRAC_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last_phase(last_phase)
    );

    fcs_update #(.FRAC_W(FRAC_W)) u_update (
        .clk(clk), .rst_n(rst_n),
        .kick_pend(kick_pend), .last_phase(last_phase),
        .pend_field(pend_field), .apply(apply),
        .active_field(active_field), .mult(mult)
    );

    fcs_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .mult(mult), .en(clk_en)
    );

endmodule

// File: rtl/fcs_chk.sv
// Property checker for the fractional clock scaler, bound to the top.
// It keeps its own per-frame enable count and idle-run length.
module fcs_chk #(
    parameter int FRAC_W = 5,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] RATIO_ADDR = 12'h0E0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [FRAC_W-1:0] phase,
    input logic              kick_pend,
    input logic [FRAC_W-1:0] pend_field,
    input logic [FRAC_W-1:0] active_field,
    input logic [FRAC_W:0]   mult,
    input logic              clk_en
);

    localparam int FRAME = 1 << FRAC_W;

    logic [FRAC_W:0]     en_cnt;
    logic [FRAC_W:0]     idle_q;
    logic [FRAC_W:0]     idle_now;
    logic [2*FRAC_W+1:0] idle_prod;
    logic                frame_end;

    assign frame_end = &phase;

    // Enables seen so far in the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)         en_cnt <= '0;
        else if (frame_end) en_cnt <= '0;
        else                en_cnt <= en_cnt + (FRAC_W+1)'(clk_en);
    end

    // Length of the current run of idle cycles before this one
    always_ff @(posedge clk) begin
        if (!rst_n)      idle_q <= '0;
        else if (clk_en) idle_q <= '0;
        else if (!(&idle_q)) idle_q <= idle_q + 1'b1;
    end

    assign idle_now  = clk_en ? '0 : idle_q + 1'b1;
    assign idle_prod = (2*FRAC_W+2)'(idle_now) * (2*FRAC_W+2)'(mult);

    // R6
    frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ((en_cnt + (FRAC_W+1)'(clk_en)) == mult));

    // R7
    enable_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_prod < (2*FRAC_W+2)'(FRAME));

    // R5
    kick_clears_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick_pend) |-> ($past(phase) == FRAC_W'(FRAME - 1)));

    // R5
    apply_loads_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick_pend) |-> (active_field == $past(pend_field)));

    // R4
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(kick_pend && frame_end) |=> $stable(active_field));

    // R8
    busy_write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_pend && reg_wr && reg_addr == RATIO_ADDR) |=> $stable(pend_field));

endmodule

bind frac_clk_scaler fcs_chk #(
    .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .RATIO_ADDR(RATIO_ADDR)
) u_fcs_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .phase(phase), .kick_pend(kick_pend), .pend_field(pend_field),
    .active_field(active_field), .mult(mult), .clk_en(clk_en)
);

// File: tb/tb_frac_clk_scaler.sv
// Directed bench for the fractional clock scaler. Each task is one scenario
// and checks its own results.
module tb_frac_clk_scaler;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_RATIO = 12'h0E0;
    localparam logic [11:0] A_CTRL  = 12'h004;
    localparam logic [11:0] A_OTHER = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int vec_cnt = 0;
    int err_cnt = 0;

    frac_clk_scaler dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clk_en(clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench view of the frame phase, counted from reset release
    logic [4:0] tb_phase = '0;
    always @(posedge clk) begin
        if (!rst_n) tb_phase <= '0;
        else        tb_phase <= tb_phase + 5'd1;
    end

    // Per-frame enable count and longest idle run
    int cur_cnt = 0, cur_run = 0, cur_max = 0;
    int last_cnt = 0, last_max = 0, frames = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tb_phase == 5'd0) begin
                cur_cnt = clk_en ? 1 : 0;
                cur_run = clk_en ? 0 : 1;
                cur_max = cur_run;
            end else begin
                cur_cnt = cur_cnt + (clk_en ? 1 : 0);
                cur_run = clk_en ? 0 : cur_run + 1;
                if (cur_run > cur_max) cur_max = cur_run;
            end
            if (tb_phase == 5'd31) begin
                last_cnt = cur_cnt;
                last_max = cur_max;
                frames   = frames + 1;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                            output logic [4:0] ph);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d  = reg_rdata;
        ph = tb_phase;
        reg_rd = 1'b0;
    endtask

    task automatic wait_phase(input logic [4:0] p);
        do @(negedge clk); while (tb_phase != p);
    endtask

    task automatic wait_frame();
        int n;
        n = frames;
        wait (frames != n);
    endtask

    // Poll the kick bit until clear; report busy polls and clearing phase
    task automatic poll_kick(output int busy, output logic [4:0] ph);
        logic [31:0] d;
        busy = 0;
        for (int i = 0; i < 80; i++) begin
            bus_read(A_CTRL, d, ph);
            if (!d[31]) return;
            busy++;
        end
    endtask

    task automatic check_rate(input string req_cnt, input int m);
        int exp_run;
        exp_run = (32 + m - 1) / m - 1;
        wait_frame();
        wait_frame();
        chk(req_cnt, "enables per frame", 32'(last_cnt), 32'(m));
        chk("R7", "longest idle run", 32'(last_max), 32'(exp_run));
    endtask

    function automatic logic [31:0] ratio_word(input logic [31:0] upper, input int m);
        return (upper & ~32'h0000_1F00) | (32'((32 - m) & 31) << 8);
    endfunction

    // Scenario: state right after reset
    task automatic t_reset();
        logic [31:0] d; logic [4:0] ph;
        bus_read(A_RATIO, d, ph); chk("R1", "ratio after reset", d, 32'h0);
        bus_read(A_CTRL, d, ph);  chk("R1", "ctrl after reset", d, 32'h0);
        check_rate("R1", 32);
    endtask

    // Scenario: readback with no kick, rate held
    task automatic t_no_kick();
        logic [31:0] d; logic [4:0] ph;
        bus_write(A_RATIO, 32'h5A5A_1234);
        bus_read(A_RATIO, d, ph); chk("R2", "ratio readback", d, 32'h5A5A_1234);
        check_rate("R4", 32);
        bus_write(A_CTRL, 32'h1234_5678);
        bus_read(A_CTRL, d, ph); chk("R3", "ctrl readback no kick", d, 32'h1234_5678);
        check_rate("R4", 32);
    endtask

    // Scenario: program a ratio, kick, poll, measure
    task automatic t_apply(input int m, input logic [31:0] upper);
        logic [31:0] d, w; logic [4:0] ph; int busy;
        w = ratio_word(upper, m);
        wait_phase(5'd3);
        bus_write(A_RATIO, w);
        bus_write(A_CTRL, 32'h8000_0A0A);
        poll_kick(busy, ph);
        chk("R5", "phase of kick clear", 32'(ph), 32'h0);
        bus_read(A_CTRL, d, ph); chk("R3", "ctrl after clear", d, 32'h0000_0A0A);
        bus_read(A_RATIO, d, ph); chk("R2", "ratio readback", d, w);
        check_rate("R6", m);
    endtask

    // Scenario: refused writes while the kick is pending
    task automatic t_busy(input int ma, input int mb);
        logic [31:0] d, wa; logic [4:0] ph; int busy;
        wa = ratio_word(32'hC000_0001, ma);
        wait_phase(5'd2);
        bus_write(A_RATIO, wa);
        bus_write(A_CTRL, 32'h8000_0000);
        bus_write(A_RATIO, ratio_word(32'h0000_0000, mb));
        bus_write(A_CTRL, 32'h0000_0000);
        bus_read(A_CTRL, d, ph); chk("R3", "kick kept after writing 0", 32'(d[31]), 32'h1);
        bus_read(A_RATIO, d, ph); chk("R8", "ratio refused while busy", d, wa);
        poll_kick(busy, ph);
        chk("R5", "phase of kick clear", 32'(ph), 32'h0);
        check_rate("R8", ma);
    endtask

    // Scenario: kick written in phase 31 applies one frame later
    task automatic t_late_kick(input int m);
        logic [31:0] d; logic [4:0] ph; int busy;
        wait_phase(5'd3);
        bus_write(A_RATIO, ratio_word(32'h0, m));
        wait_phase(5'd30);
        bus_write(A_CTRL, 32'h8000_0000);
        poll_kick(busy, ph);
        chk("R5", "busy polls for late kick", 32'(busy), 32'd31);
        chk("R5", "phase of late kick clear", 32'(ph), 32'h0);
        check_rate("R6", m);
    endtask

    // Scenario: ratio write lands on the apply cycle itself
    task automatic t_apply_edge(input int ma, input int mb);
        logic [31:0] d, wa; logic [4:0] ph; int busy;
        wa = ratio_word(32'h0000_00F0, ma);
        wait_phase(5'd3);
        bus_write(A_RATIO, wa);
        bus_write(A_CTRL, 32'h8000_0000);
        wait_phase(5'd30);
        bus_write(A_RATIO, ratio_word(32'h0, mb));
        bus_read(A_RATIO, d, ph); chk("R8", "ratio write in apply cycle", d, wa);
        bus_read(A_CTRL, d, ph); chk("R5", "kick cleared at apply", 32'(d[31]), 32'h0);
        check_rate("R8", ma);
    endtask

    // Scenario: unmapped address and idle read strobe
    task automatic t_unmapped();
        logic [31:0] d, r0, c0; logic [4:0] ph;
        bus_read(A_RATIO, r0, ph);
        bus_read(A_CTRL, c0, ph);
        bus_write(A_OTHER, 32'hFFFF_FFFF);
        bus_read(A_OTHER, d, ph); chk("R9", "unmapped read", d, 32'h0);
        bus_read(A_RATIO, d, ph); chk("R9", "ratio untouched", d, r0);
        bus_read(A_CTRL, d, ph);  chk("R9", "ctrl untouched", d, c0);
        @(negedge clk);
        reg_addr = A_RATIO;
        #1;
        chk("R9", "rdata with read strobe low", reg_rdata, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_kick();
        t_apply(18, 32'h0);        // pending code from t_no_kick is replaced
        t_apply(1, 32'hFFFF_E0FF);
        t_apply(16, 32'h0);
        t_apply(31, 32'h1234_0000);
        t_apply(5, 32'h0);
        t_apply(32, 32'h0);
        t_busy(9, 20);
        t_late_kick(12);
        t_apply_edge(7, 27);
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        vec_cnt++;
        err_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

endmodule